// File: doc/BRIEF.md
# Mapping Table Entry Writer

This block installs or removes one 64-bit entry in an in-memory mapping table. A requester hands it an index, a map/unmap flag and a payload. The payload is either a collection entry (a target processor number) or a device entry (a size field and a translation-table address). The block assembles the entry and stores it through a single 64-bit memory port. It then reports completion with a one-cycle done pulse that carries an error flag.

The table is either flat or two-level, chosen by a configuration flag. In flat mode the entry address is computed directly from the base. In two-level mode the block first fetches a level-1 descriptor that points to a level-2 page, and stores the entry inside that page. If the descriptor is not marked valid, the store is skipped and the request still succeeds. Page size and entry size are given as base-two logarithms, so index splitting needs only shifts and masks.

The configuration inputs (table valid, indirect, base, page size, entry size) must hold steady while a request is in flight.

Top module: `tbl_entry_writer`

## Requirements
- R1: When `cfg_tbl_valid` is low, an accepted request makes no memory access and raises `done` with `done_err` low in the cycle right after acceptance.
- R2: In flat mode (`cfg_indirect` low), exactly one write is made, at address `cfg_base + index*8`.
- R3: In two-level mode, a level-1 descriptor is first read from `cfg_base + (index >> (cfg_page_log2-3))*8`.
- R4: A descriptor is valid when its bit 63 is 1, and its bits 50:0 give the level-2 page address. With a valid descriptor, the entry is written at `page + (index mod 2^(cfg_page_log2-cfg_esize_log2)) * 2^cfg_esize_log2`.
- R5: When the descriptor has bit 63 clear, no write is made and the request completes with `done_err` low.
- R6: With `req_kind`=0 (collection) and `req_map`=1, the entry is bit 0 = 1 and bits 16:1 = target, with all other bits zero.
- R7: With `req_kind`=1 (device) and `req_map`=1, the entry is bit 0 = 1, bits 5:1 = size and bits 49:6 = table address, with all other bits zero.
- R8: With `req_map`=0, the written entry is all zeros, for either kind.
- R9: An error response to the level-1 read ends the request with `done_err` high and no write.
- R10: An error response to the entry write ends the request with `done_err` high.
- R11: `req_ready` is high only while idle. `done` is a single-cycle pulse that arrives one cycle after the acknowledge of the last memory access, and the block is ready again in the next cycle.
- R12: Once `mem_req` is raised, it stays high with `mem_addr` and `mem_we` unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_kind | input | 1 | 0 = collection entry, 1 = device entry |
| req_map | input | 1 | 1 = install mapping, 0 = unmap (zero entry) |
| req_index | input | IDX_W | Table index |
| req_target | input | TGT_W | Target processor number (collection) |
| req_size | input | SZ_W | Size field (device) |
| req_itt | input | ITT_W | Translation-table address field (device) |
| cfg_tbl_valid | input | 1 | Table is in use |
| cfg_indirect | input | 1 | 1 = two-level table |
| cfg_base | input | ADDR_W | Table base byte address |
| cfg_page_log2 | input | PG_W | log2 of page size in bytes (at least 3) |
| cfg_esize_log2 | input | ES_W | log2 of entry size in bytes (not above page) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed (valid with ack) |
| mem_rdata | input | 64 | Read data (valid with ack) |
| done | output | 1 | Request finished (one cycle) |
| done_err | output | 1 | Request status, 1 = error |

## Verification
After acceptance, each memory access stays open until its acknowledge. The done pulse is due exactly one cycle after the last acknowledge, or one cycle after acceptance when the table is off. The bench keeps a cycle count from the acceptance edge, along with the number of cycles the port was busy, and compares the cycle on which done appears with that busy count plus one. It also adds random wait states before each acknowledge, so this timing is checked under stretched accesses as well as immediate ones. All outputs are sampled on the falling edge, and the addresses and data are recorded on the cycle each access is acknowledged.

// File: rtl/tew_pkg.sv
// Shared types and fixed field positions for the mapping table entry writer.
// Assumes a 64-bit memory word and 8-byte level-1 descriptors.
package tew_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_L1RD  = 2'd1,
        ST_WRITE = 2'd2,
        ST_RESP  = 2'd3
    } tew_state_t;

    localparam int DESC_VALID_BIT  = 63;
    localparam int L2_ADDR_MSB     = 50;
    localparam int DESC_BYTES_LOG2 = 3;
endpackage

// File: rtl/tew_entry_build.sv
// Assembles a 64-bit table entry from the request payload.
// kind=0: collection (valid in bit 0, target above it).
// kind=1: device (valid in bit 0, size, then table address).
// map=0 yields an all-zero entry. Assumes SZ_W+ITT_W < 64 and TGT_W < 64.
module tew_entry_build #(
    parameter int TGT_W = 16,
    parameter int SZ_W  = 5,
    parameter int ITT_W = 44
) (
    input  logic             kind,
    input  logic             map,
    input  logic [TGT_W-1:0] target,
    input  logic [SZ_W-1:0]  size,
    input  logic [ITT_W-1:0] itt,
    output logic [63:0]      entry
);
    localparam int ITT_LSB = SZ_W + 1;
    localparam int ITT_MSB = SZ_W + ITT_W;

    // Place payload fields by entry kind.
    always_comb begin
        entry = '0;
        if (map) begin
            entry[0] = 1'b1;
            if (kind) begin
                entry[SZ_W:1]          = size;
                entry[ITT_MSB:ITT_LSB] = itt;
            end else begin
                entry[TGT_W:1] = target;
            end
        end
    end
endmodule

// File: rtl/tew_addr_gen.sv
// Computes the flat entry address, the level-1 descriptor address and the
// level-2 entry address. Page and entry sizes are powers of two given as
// log2; assumes page_log2 >= 3 and esize_log2 <= page_log2.
module tew_addr_gen
    import tew_pkg::*;
#(
    parameter int ADDR_W = 52,
    parameter int IDX_W  = 32,
    parameter int PG_W   = 5,
    parameter int ES_W   = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  index,
    input  logic [PG_W-1:0]   page_log2,
    input  logic [ES_W-1:0]   esize_log2,
    input  logic [ADDR_W-1:0] l2_base,
    output logic [ADDR_W-1:0] flat_addr,
    output logic [ADDR_W-1:0] l1_addr,
    output logic [ADDR_W-1:0] l2_addr
);
    logic [PG_W-1:0]  l1_shift;
    logic [PG_W-1:0]  slot_bits;
    logic [IDX_W-1:0] l1_idx;
    logic [IDX_W-1:0] slot_mask;
    logic [IDX_W-1:0] slot;

    // Split the index: page number selects the descriptor, low bits the slot.
    always_comb begin
        l1_shift  = page_log2 - PG_W'(DESC_BYTES_LOG2);
        slot_bits = page_log2 - PG_W'(esize_log2);
        l1_idx    = index >> l1_shift;
        slot_mask = (IDX_W'(1) << slot_bits) - IDX_W'(1);
        slot      = index & slot_mask;
    end

    // Form the three candidate byte addresses.
    always_comb begin
        flat_addr = base + (ADDR_W'(index) << DESC_BYTES_LOG2);
        l1_addr   = base + (ADDR_W'(l1_idx) << DESC_BYTES_LOG2);
        l2_addr   = l2_base + (ADDR_W'(slot) << esize_log2);
    end
endmodule

// File: rtl/tbl_entry_writer.sv
// Mapping table entry writer: takes one request at a time, optionally walks
// a level-1 descriptor, writes the entry and pulses done with a status.
// Assumes configuration inputs stay stable while a request is in flight,
// and ADDR_W >= 51 so a full level-2 page address fits.
module tbl_entry_writer
    import tew_pkg::*;
#(
    parameter int ADDR_W = 52,
    parameter int IDX_W  = 32,
    parameter int TGT_W  = 16,
    parameter int SZ_W   = 5,
    parameter int ITT_W  = 44,
    parameter int PG_W   = 5,
    parameter int ES_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_kind,
    input  logic              req_map,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [TGT_W-1:0]  req_target,
    input  logic [SZ_W-1:0]   req_size,
    input  logic [ITT_W-1:0]  req_itt,
    input  logic              cfg_tbl_valid,
    input  logic              cfg_indirect,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [PG_W-1:0]   cfg_page_log2,
    input  logic [ES_W-1:0]   cfg_esize_log2,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [63:0]       mem_rdata,
    output logic              done,
    output logic              done_err
);
    tew_state_t        state;
    logic [IDX_W-1:0]  cap_index;
    logic [63:0]       cap_entry;
    logic [ADDR_W-1:0] cap_l2;
    logic              err_q;
    logic [63:0]       built_entry;
    logic [ADDR_W-1:0] flat_addr;
    logic [ADDR_W-1:0] l1_addr;
    logic [ADDR_W-1:0] l2_addr;

    tew_entry_build #(.TGT_W(TGT_W), .SZ_W(SZ_W), .ITT_W(ITT_W)) u_build (
        .kind   (req_kind),
        .map    (req_map),
        .target (req_target),
        .size   (req_size),
        .itt    (req_itt),
        .entry  (built_entry)
    );

    tew_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PG_W(PG_W), .ES_W(ES_W)) u_addr (
        .base       (cfg_base),
        .index      (cap_index),
        .page_log2  (cfg_page_log2),
        .esize_log2 (cfg_esize_log2),
        .l2_base    (cap_l2),
        .flat_addr  (flat_addr),
        .l1_addr    (l1_addr),
        .l2_addr    (l2_addr)
    );

    // Walk sequencer: accept, optional descriptor fetch, write, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cap_index <= '0;
            cap_entry <= '0;
            cap_l2    <= '0;
            err_q     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cap_index <= req_index;
                        cap_entry <= built_entry;
                        err_q     <= 1'b0;
                        if (!cfg_tbl_valid)    state <= ST_RESP;
                        else if (cfg_indirect) state <= ST_L1RD;
                        else                   state <= ST_WRITE;
                    end
                end
                ST_L1RD: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            err_q <= 1'b1;
                            state <= ST_RESP;
                        end else if (mem_rdata[DESC_VALID_BIT]) begin
                            cap_l2 <= ADDR_W'(mem_rdata[L2_ADDR_MSB:0]);
                            state  <= ST_WRITE;
                        end else begin
                            state <= ST_RESP;
                        end
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) begin
                        err_q <= mem_err;
                        state <= ST_RESP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive handshake, memory port and completion outputs from the state.
    always_comb begin
        req_ready = (state == ST_IDLE);
        mem_req   = (state == ST_L1RD) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_wdata = cap_entry;
        if (state == ST_L1RD)  mem_addr = l1_addr;
        else if (cfg_indirect) mem_addr = l2_addr;
        else                   mem_addr = flat_addr;
        done      = (state == ST_RESP);
        done_err  = (state == ST_RESP) && err_q;
    end
endmodule

// File: rtl/tew_checker.sv
// Protocol and outcome properties for tbl_entry_writer, observed at its ports.
// Keeps its own copy of the accepted index and map flag.
module tew_checker #(
    parameter int ADDR_W = 52,
    parameter int IDX_W  = 32,
    parameter int PG_W   = 5,
    parameter int ES_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_map,
    input logic [IDX_W-1:0]  req_index,
    input logic              cfg_tbl_valid,
    input logic              cfg_indirect,
    input logic [ADDR_W-1:0] cfg_base,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [63:0]       mem_wdata,
    input logic              mem_ack,
    input logic              mem_err,
    input logic [63:0]       mem_rdata,
    input logic              done,
    input logic              done_err
);
    logic [IDX_W-1:0] c_idx;
    logic             c_map;

    // Capture the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_idx <= '0;
            c_map <= 1'b0;
        end else if (req_valid && req_ready) begin
            c_idx <= req_index;
            c_map <= req_map;
        end
    end

    p_tbl_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !cfg_tbl_valid |=> done && !done_err && !mem_req);

    p_flat_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && !cfg_indirect |-> mem_addr == cfg_base + (ADDR_W'(c_idx) << 3));

    p_desc_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && !mem_we && !mem_err && !mem_rdata[63] |=> done && !done_err);

    p_unmap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && !c_map |-> mem_wdata == 64'd0);

    p_l1_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && !mem_we && mem_err |=> done && done_err);

    p_wr_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && mem_we && mem_err |=> done && done_err);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    p_hold_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
endmodule

bind tbl_entry_writer tew_checker #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PG_W(PG_W), .ES_W(ES_W)
) u_tew_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_map(req_map), .req_index(req_index), .cfg_tbl_valid(cfg_tbl_valid),
    .cfg_indirect(cfg_indirect), .cfg_base(cfg_base), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .done(done), .done_err(done_err)
);

// File: tb/test_tbl_entry_writer.sv
`timescale 1ns/1ps
module test_tbl_entry_writer;
    localparam int AW = 52;
    localparam int IW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_kind = 1'b0;
    logic          req_map = 1'b0;
    logic [IW-1:0] req_index = '0;
    logic [15:0]   req_target = '0;
    logic [4:0]    req_size = '0;
    logic [43:0]   req_itt = '0;
    logic          cfg_tbl_valid = 1'b0;
    logic          cfg_indirect = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [4:0]    cfg_page_log2 = 5'd12;
    logic [2:0]    cfg_esize_log2 = 3'd3;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata;
    logic          mem_ack = 1'b0;
    logic          mem_err = 1'b0;
    logic [63:0]   mem_rdata = '0;
    logic          done;
    logic          done_err;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    tbl_entry_writer i_tbl_entry_writer (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] model_entry(input logic kind, input logic map,
        input logic [15:0] tgt, input logic [4:0] sz, input logic [43:0] itt);
        logic [63:0] e;
        e = 64'd0;
        if (map) begin
            if (kind) e = {14'd0, itt, sz, 1'b1};
            else      e = {47'd0, tgt, 1'b1};
        end
        return e;
    endfunction

    function automatic logic [AW-1:0] model_l1(input logic [IW-1:0] idx);
        logic [63:0] pg;
        pg = 64'd1 << cfg_page_log2;
        return cfg_base + AW'((64'(idx) / (pg / 8)) * 8);
    endfunction

    function automatic logic [AW-1:0] model_l2(input logic [63:0] desc, input logic [IW-1:0] idx);
        logic [63:0] per, es;
        es  = 64'd1 << cfg_esize_log2;
        per = (64'd1 << cfg_page_log2) / es;
        return AW'(desc[50:0]) + AW'((64'(idx) % per) * es);
    endfunction

    task automatic run_req(input logic kind, input logic map, input logic [IW-1:0] idx,
                           input logic [15:0] tgt, input logic [4:0] sz, input logic [43:0] itt,
                           input logic [63:0] desc, input bit l1err, input bit werr);
        bit exp_rd, exp_wr, exp_err;
        int cyc, busy, nrd, nwr, waitn;
        logic [AW-1:0] ra, wa, hold;
        logic [63:0] wd, ent;
        bit holding;
        ent = model_entry(kind, map, tgt, sz, itt);
        exp_rd  = cfg_tbl_valid && cfg_indirect;
        exp_wr  = cfg_tbl_valid && (!cfg_indirect || (!l1err && desc[63]));
        exp_err = (exp_rd && l1err) || (exp_wr && werr);
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready when idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_kind = kind; req_map = map; req_index = idx;
        req_target = tgt; req_size = sz; req_itt = itt;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1; busy = 0; nrd = 0; nwr = 0; ra = '0; wa = '0; wd = '0;
        waitn = $urandom % 3; holding = 1'b0; hold = '0;
        forever begin
            mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
            if (done || cyc > 60) break;
            if (req_ready)
                chk(1'b0, "R11", "ready while busy", 64'd1, 64'd0);
            if (mem_req) begin
                busy++;
                if (holding)
                    chk(mem_addr == hold, "R12", "address held", 64'(mem_addr), 64'(hold));
                if (waitn > 0) begin
                    waitn--; holding = 1'b1; hold = mem_addr;
                end else begin
                    holding = 1'b0;
                    mem_ack = 1'b1;
                    waitn = $urandom % 3;
                    if (mem_we) begin
                        nwr++; wa = mem_addr; wd = mem_wdata; mem_err = werr;
                    end else begin
                        nrd++; ra = mem_addr; mem_rdata = desc; mem_err = l1err;
                    end
                end
            end
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R11", "done seen", 64'(done), 64'd1);
        chk(cyc == busy + 1, "R11", "done latency", 64'(cyc), 64'(busy + 1));
        if (!cfg_tbl_valid)
            chk(cyc == 1, "R1", "no-table latency", 64'(cyc), 64'd1);
        chk(done_err == exp_err, exp_rd && l1err ? "R9" : (werr ? "R10" : "R5"),
            "status", 64'(done_err), 64'(exp_err));
        chk(nrd == int'(exp_rd), exp_rd ? "R3" : "R1", "read count", 64'(nrd), 64'(exp_rd));
        chk(nwr == int'(exp_wr), cfg_indirect ? "R5" : "R2", "write count", 64'(nwr), 64'(exp_wr));
        if (exp_rd && nrd == 1)
            chk(ra == model_l1(idx), "R3", "descriptor address", 64'(ra), 64'(model_l1(idx)));
        if (exp_wr && nwr == 1) begin
            if (cfg_indirect)
                chk(wa == model_l2(desc, idx), "R4", "level-2 address", 64'(wa), 64'(model_l2(desc, idx)));
            else
                chk(wa == cfg_base + AW'(64'(idx) * 8), "R2", "flat address", 64'(wa),
                    64'(cfg_base + AW'(64'(idx) * 8)));
            chk(wd == ent, !map ? "R8" : (kind ? "R7" : "R6"), "entry data", wd, ent);
        end
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R11", "done is one pulse",
            64'({done, req_ready}), 64'b01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R11 watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && !mem_req, "R11", "reset state",
            64'({req_ready, done, mem_req}), 64'b100);

        // R1: table off
        cfg_tbl_valid = 1'b0; cfg_indirect = 1'b1;
        run_req(1'b1, 1'b1, 32'd7, 16'd0, 5'd3, 44'h123, 64'h8000_0000_0001_0000, 1'b0, 1'b0);
        // R2 and R6: flat collection
        cfg_tbl_valid = 1'b1; cfg_indirect = 1'b0; cfg_base = 52'h0_0001_2340_0000;
        run_req(1'b0, 1'b1, 32'd5, 16'hBEEF, 5'd0, 44'd0, 64'd0, 1'b0, 1'b0);
        // R7: flat device, all fields at maximum
        run_req(1'b1, 1'b1, 32'h0000_FFFF, 16'hFFFF, 5'h1F, 44'hFFF_FFFF_FFFF, 64'd0, 1'b0, 1'b0);
        // R8: unmap
        run_req(1'b1, 1'b0, 32'd9, 16'h1, 5'h1F, 44'h5A5, 64'd0, 1'b0, 1'b0);
        // R10: write error
        run_req(1'b0, 1'b1, 32'd1, 16'h2, 5'd0, 44'd0, 64'd0, 1'b0, 1'b1);
        // R3, R4: two-level, last slot of a page, descriptor with junk high bits
        cfg_indirect = 1'b1; cfg_page_log2 = 5'd12; cfg_esize_log2 = 3'd3;
        run_req(1'b0, 1'b1, 32'd1023, 16'h42, 5'd0, 44'd0, 64'hFFF8_0000_0055_5000, 1'b0, 1'b0);
        run_req(1'b1, 1'b1, 32'd1024, 16'h0, 5'd4, 44'h777, 64'h8000_0000_0066_6000, 1'b0, 1'b0);
        // R5: invalid descriptor
        run_req(1'b1, 1'b1, 32'd3, 16'h0, 5'd4, 44'h777, 64'h7FFF_FFFF_FFFF_F000, 1'b0, 1'b0);
        // R9: descriptor read error
        run_req(1'b1, 1'b1, 32'd3, 16'h0, 5'd4, 44'h777, 64'h8000_0000_0066_6000, 1'b1, 1'b0);

        for (int n = 0; n < 300; n++) begin
            logic [63:0] d;
            cfg_tbl_valid  = ($urandom % 8) != 0;
            cfg_indirect   = $urandom % 2;
            cfg_page_log2  = 5'(12 + $urandom % 5);
            cfg_esize_log2 = 3'(3 + $urandom % 2);
            cfg_base       = AW'({$urandom, $urandom}) & ~AW'(12'hFFF);
            d = {$urandom, $urandom};
            run_req(1'($urandom), ($urandom % 4) != 0, $urandom % 32'h0010_0000,
                    16'($urandom), 5'($urandom), 44'({$urandom, $urandom}),
                    d, ($urandom % 8) == 0, ($urandom % 8) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule